// File: doc/BRIEF.md
# DRAM Power-Up Mode Register Sequencer

This block runs the power-up command sequence of a double-data-rate memory, for either the first-generation (DDR1) or second-generation (DDR2) command set. A single start pulse launches the run. The variant select is sampled at that moment and kept until the run ends. For each step the block issues a one-cycle, one-hot command strobe. When a step loads a mode or extended-mode register, the matching value word is presented before the strobe and held after it. After each strobe the block waits a set number of clock cycles before the next step: a short count or a long count, chosen per step.

At the end of the sequence the block presents a refresh control word with the enable bit set and the fixed interval, and a read-strobe delay tap value for two byte lanes. It then raises done and keeps it high until reset. The block produces only abstract strobes and value words. A downstream command path turns them into memory pin activity, and a separate refresh engine uses the refresh word.

Top module: `dram_init_seq`

## Requirements
- R1: `cmd_strobe` is one-hot or zero, and any strobe is high for exactly one clock. Bit positions: bit 0 mode register load, bit 1 extended mode load, bit 2 auto refresh, bit 3 precharge all, bit 4 extended register 2 load, bit 5 extended register 3 load.
- R2: With DDR1 selected at start, the strobes are, in order:
  - precharge (8)
  - extended mode load with `emode_word` 0x000 (2)
  - mode load with `mode_word` 0x133 (1)
  - precharge (8)
  - auto refresh (4)
  - auto refresh (4)
  - mode load with `mode_word` 0x033 (1)
- R3: With DDR2 selected at start, the strobes are, in order:
  - two leading strobes: ext-2 (16), then ext-3 (32)
  - precharge (8), ext-2 (16), ext-3 (32)
  - extended mode load with 0x402 (2)
  - mode load with 0x143 (1)
  - precharge (8)
  - two auto refreshes (4)
  - mode load with 0x043 (1)
- R4: DDR2 only: after the final mode load there are two more extended mode loads. The first carries 0x782 (drive calibration default). The second carries 0x402 (calibration exit).
- R5: At every mode or extended-mode load strobe, the matching value word already had the same value in the previous cycle, and both words stay unchanged in the cycle after any strobe.
- R6: Consecutive strobes are exactly W+2 cycles apart. W is SHORT_WAIT after the two DDR2 leading strobes and LONG_WAIT after every other step. `done` rises exactly LONG_WAIT cycles after the last strobe.
- R7: `refresh_ctrl_word` is zero before done. From done on it equals enable bit 14 set plus REF_PERIOD (312) in bits 9:0, i.e. 0x4138.
- R8: From done on, both `dqs_tap_lane0` and `dqs_tap_lane1` equal 0x20 for DDR1 and 0x10 for DDR2. Both are zero before done.
- R9: `busy` is high from the cycle after an accepted start until done. `done` stays high with no further strobes until reset.
- R10: Without a start pulse no strobe is issued. A start pulse while busy or after done is ignored.
- R11: A change of `ddr2_sel` after the start pulse has no effect on the running sequence or on the final tap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| ddr2_sel | input | 1 | Variant select sampled at start: 1 = DDR2, 0 = DDR1 |
| cmd_strobe | output | 6 | One-hot command strobe (encoding in R1) |
| mode_word | output | 13 | Value for mode register loads |
| emode_word | output | 13 | Value for extended mode register loads |
| refresh_ctrl_word | output | 16 | Refresh enable (bit 14) and interval (bits 9:0) |
| dqs_tap_lane0 | output | 6 | Read-strobe delay tap, byte lane 0 |
| dqs_tap_lane1 | output | 6 | Read-strobe delay tap, byte lane 1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The assertions treat `start` as a synchronous signal. They expect SHORT_WAIT and LONG_WAIT to be at least one, so that a strobe is always followed by quiet cycles, and they place no constraint on when `ddr2_sel` changes. The stimulus changes `start` and `ddr2_sel` only on falling clock edges and pulses `start` for one cycle. It deliberately toggles `ddr2_sel` mid-run and repeats `start` mid-run and after done, to show that the sampled variant and the sticky done hold.

// File: rtl/dram_init_pkg.sv
`timescale 1ns/1ps
package dram_init_pkg;

  localparam int CMD_W   = 6;
  localparam int WORD_W  = 13;
  localparam int TAP_W   = 6;
  localparam int REF_W   = 16;
  localparam int REF_EN_BIT = 14;
  localparam int REF_PER_W  = 10;
  localparam int STEP_N  = 13;
  localparam int STEP_IW = $clog2(STEP_N);

  // command strobe bit positions (decoded downstream)
  localparam int CB_MODE = 0;
  localparam int CB_EXT  = 1;
  localparam int CB_AREF = 2;
  localparam int CB_PALL = 3;
  localparam int CB_EXT2 = 4;
  localparam int CB_EXT3 = 5;

  localparam logic [WORD_W-1:0] W_EXT_GEN1   = 13'h000;
  localparam logic [WORD_W-1:0] W_EXT_GEN2   = 13'h402;
  localparam logic [WORD_W-1:0] W_EXT_CALDEF = 13'h782;
  localparam logic [WORD_W-1:0] W_MR_RST1    = 13'h133;
  localparam logic [WORD_W-1:0] W_MR_RST2    = 13'h143;
  localparam logic [WORD_W-1:0] W_MR_RUN1    = 13'h033;
  localparam logic [WORD_W-1:0] W_MR_RUN2    = 13'h043;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic              ld_mode;
    logic              ld_ext;
    logic [WORD_W-1:0] word;
    logic              long_wait;
    logic              gen2_only;
  } step_t;

  function automatic logic [CMD_W-1:0] strobe_bit(input int pos);
    return CMD_W'(1) << pos;
  endfunction

  // Shared step list; gen2_only entries are skipped for DDR1.
  function automatic step_t step_of(input int idx, input logic gen2);
    step_t s;
    s = '0;
    s.long_wait = 1'b1;
    case (idx)
      0:  begin s.cmd = strobe_bit(CB_EXT2); s.long_wait = 1'b0; s.gen2_only = 1'b1; end
      1:  begin s.cmd = strobe_bit(CB_EXT3); s.long_wait = 1'b0; s.gen2_only = 1'b1; end
      2:  s.cmd = strobe_bit(CB_PALL);
      3:  begin s.cmd = strobe_bit(CB_EXT2); s.gen2_only = 1'b1; end
      4:  begin s.cmd = strobe_bit(CB_EXT3); s.gen2_only = 1'b1; end
      5:  begin s.cmd = strobe_bit(CB_EXT);  s.ld_ext = 1'b1;
                s.word = gen2 ? W_EXT_GEN2 : W_EXT_GEN1; end
      6:  begin s.cmd = strobe_bit(CB_MODE); s.ld_mode = 1'b1;
                s.word = gen2 ? W_MR_RST2 : W_MR_RST1; end
      7:  s.cmd = strobe_bit(CB_PALL);
      8:  s.cmd = strobe_bit(CB_AREF);
      9:  s.cmd = strobe_bit(CB_AREF);
      10: begin s.cmd = strobe_bit(CB_MODE); s.ld_mode = 1'b1;
                s.word = gen2 ? W_MR_RUN2 : W_MR_RUN1; end
      11: begin s.cmd = strobe_bit(CB_EXT);  s.ld_ext = 1'b1;
                s.word = W_EXT_CALDEF; s.gen2_only = 1'b1; end
      12: begin s.cmd = strobe_bit(CB_EXT);  s.ld_ext = 1'b1;
                s.word = W_EXT_GEN2; s.gen2_only = 1'b1; end
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic step_used(input int idx, input logic gen2);
    step_t s;
    s = step_of(idx, gen2);
    return gen2 || !s.gen2_only;
  endfunction

  function automatic logic [STEP_IW-1:0] first_step(input logic gen2);
    int r;
    r = 0;
    for (int j = STEP_N - 1; j >= 0; j--) begin
      if (step_used(j, gen2)) r = j;
    end
    return STEP_IW'(r);
  endfunction

  function automatic logic [REF_W-1:0] refresh_word(input int period);
    logic [REF_W-1:0] w;
    w = '0;
    w[REF_EN_BIT] = 1'b1;
    w[REF_PER_W-1:0] = REF_PER_W'(period);
    return w;
  endfunction

endpackage

// File: rtl/dram_init_step_rom.sv
`timescale 1ns/1ps
module dram_init_step_rom
  import dram_init_pkg::*;
(
  input  logic [STEP_IW-1:0] idx,
  input  logic               gen2,
  output step_t              step,
  output logic [STEP_IW-1:0] next_idx,
  output logic               is_last
);

  always_comb begin
    step = step_of(int'(idx), gen2);
  end

  // smallest used index above idx; none found means last step
  always_comb begin
    next_idx = '0;
    is_last  = 1'b1;
    for (int j = STEP_N - 1; j >= 0; j--) begin
      if (j > int'(idx) && step_used(j, gen2)) begin
        next_idx = STEP_IW'(j);
        is_last  = 1'b0;
      end
    end
  end

endmodule

// File: rtl/dram_init_wait_timer.sv
`timescale 1ns/1ps
module dram_init_wait_timer #(
  parameter int SHORT_WAIT = 8,
  parameter int LONG_WAIT  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic expired
);

  localparam int MAXW  = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CNT_W = $clog2(MAXW + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= long_sel ? CNT_W'(LONG_WAIT - 1) : CNT_W'(SHORT_WAIT - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dram_init_seq.sv
`timescale 1ns/1ps
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int SHORT_WAIT = 8,
  parameter int LONG_WAIT  = 20,
  parameter int REF_PERIOD = 312,
  parameter int TAP_GEN1   = 32,
  parameter int TAP_GEN2   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ddr2_sel,
  output logic [CMD_W-1:0]  cmd_strobe,
  output logic [WORD_W-1:0] mode_word,
  output logic [WORD_W-1:0] emode_word,
  output logic [REF_W-1:0]  refresh_ctrl_word,
  output logic [TAP_W-1:0]  dqs_tap_lane0,
  output logic [TAP_W-1:0]  dqs_tap_lane1,
  output logic              busy,
  output logic              done
);

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_ISSUE, ST_HOLD, ST_DONE} seq_state_t;

  seq_state_t         state_q;
  logic [STEP_IW-1:0] idx_q;
  logic               gen2_q;
  logic [CMD_W-1:0]   cmd_q;
  logic [WORD_W-1:0]  mode_q, emode_q;
  logic [REF_W-1:0]   ref_q;
  logic [TAP_W-1:0]   tap_q;
  logic               done_q;

  step_t              cur_step;
  logic [STEP_IW-1:0] nxt_idx;
  logic               last_step;
  logic               wait_over;

  // named events for the checker
  logic start_accept, step_issue, seq_finish;

  assign start_accept = (state_q == ST_IDLE) && start;
  assign step_issue   = (state_q == ST_ISSUE);
  assign seq_finish   = (state_q == ST_HOLD) && wait_over && last_step;

  dram_init_step_rom u_rom (
    .idx      (idx_q),
    .gen2     (gen2_q),
    .step     (cur_step),
    .next_idx (nxt_idx),
    .is_last  (last_step)
  );

  dram_init_wait_timer #(
    .SHORT_WAIT (SHORT_WAIT),
    .LONG_WAIT  (LONG_WAIT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (step_issue),
    .long_sel (cur_step.long_wait),
    .expired  (wait_over)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      gen2_q  <= 1'b0;
      cmd_q   <= '0;
      mode_q  <= '0;
      emode_q <= '0;
      ref_q   <= '0;
      tap_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      cmd_q <= '0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            gen2_q  <= ddr2_sel;
            idx_q   <= first_step(ddr2_sel);
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (cur_step.ld_mode) mode_q  <= cur_step.word;
          if (cur_step.ld_ext)  emode_q <= cur_step.word;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          cmd_q   <= cur_step.cmd;
          state_q <= ST_HOLD;
        end
        ST_HOLD: begin
          if (wait_over) begin
            if (last_step) begin
              ref_q   <= refresh_word(REF_PERIOD);
              tap_q   <= gen2_q ? TAP_W'(TAP_GEN2) : TAP_W'(TAP_GEN1);
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              idx_q   <= nxt_idx;
              state_q <= ST_LOAD;
            end
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign cmd_strobe        = cmd_q;
  assign mode_word         = mode_q;
  assign emode_word        = emode_q;
  assign refresh_ctrl_word = ref_q;
  assign dqs_tap_lane0     = tap_q;
  assign dqs_tap_lane1     = tap_q;
  assign done              = done_q;
  assign busy              = (state_q == ST_LOAD) || (state_q == ST_ISSUE) || (state_q == ST_HOLD);

endmodule

// File: rtl/dram_init_seq_chk.sv
`timescale 1ns/1ps
module dram_init_seq_chk
  import dram_init_pkg::*;
#(
  parameter int REF_PERIOD = 312
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CMD_W-1:0]  cmd_strobe,
  input logic [WORD_W-1:0] mode_word,
  input logic [WORD_W-1:0] emode_word,
  input logic [REF_W-1:0]  refresh_ctrl_word,
  input logic [TAP_W-1:0]  dqs_tap_lane0,
  input logic [TAP_W-1:0]  dqs_tap_lane1,
  input logic              busy,
  input logic              done,
  input logic              start_accept,
  input logic              seq_finish
);

  localparam logic [REF_W-1:0] REF_EXP = refresh_word(REF_PERIOD);

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_strobe));

  a_r1_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe != '0) |=> (cmd_strobe == '0));

  a_r5_mode_setup: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe[CB_MODE] |-> $stable(mode_word));

  a_r5_ext_setup: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe[CB_EXT] |-> $stable(emode_word));

  a_r5_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe != '0) |=> ($stable(mode_word) && $stable(emode_word)));

  a_r7_refresh_word: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (refresh_ctrl_word == REF_EXP));

  a_r7_refresh_off: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (refresh_ctrl_word == '0));

  a_r8_lanes_match: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_tap_lane0 == dqs_tap_lane1);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cmd_strobe == '0) && !busy));

  a_r9_finish_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    seq_finish |=> done);

  a_r9_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> busy);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (cmd_strobe == '0));

endmodule

bind dram_init_seq dram_init_seq_chk #(.REF_PERIOD(REF_PERIOD)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cmd_strobe        (cmd_strobe),
  .mode_word         (mode_word),
  .emode_word        (emode_word),
  .refresh_ctrl_word (refresh_ctrl_word),
  .dqs_tap_lane0     (dqs_tap_lane0),
  .dqs_tap_lane1     (dqs_tap_lane1),
  .busy              (busy),
  .done              (done),
  .start_accept      (start_accept),
  .seq_finish        (seq_finish)
);

// File: tb/dram_init_seq_tb_top.sv
`timescale 1ns/1ps
module dram_init_seq_tb_top;

  localparam int SH = 3;
  localparam int LG = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ddr2_sel = 1'b0;
  logic [5:0]  cmd_strobe;
  logic [12:0] mode_word, emode_word;
  logic [15:0] refresh_ctrl_word;
  logic [5:0]  dqs_tap_lane0, dqs_tap_lane1;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;

  int cap_n;
  int cap_cmd[16];
  int cap_word_m[16];
  int cap_word_e[16];
  int cap_prev_m[16];
  int cap_prev_e[16];
  int cap_cyc[16];
  int done_cyc;

  always #2.5 clk = ~clk;

  dram_init_seq #(
    .SHORT_WAIT (SH),
    .LONG_WAIT  (LG),
    .REF_PERIOD (312),
    .TAP_GEN1   (32),
    .TAP_GEN2   (16)
  ) dut_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .start             (start),
    .ddr2_sel          (ddr2_sel),
    .cmd_strobe        (cmd_strobe),
    .mode_word         (mode_word),
    .emode_word        (emode_word),
    .refresh_ctrl_word (refresh_ctrl_word),
    .dqs_tap_lane0     (dqs_tap_lane0),
    .dqs_tap_lane1     (dqs_tap_lane1),
    .busy              (busy),
    .done              (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // expected strobe list, written from R2/R3/R4
  function automatic int exp_len(input bit g2);
    return g2 ? 13 : 7;
  endfunction

  function automatic int exp_cmd(input bit g2, input int i);
    int d1[7]  = '{8, 2, 1, 8, 4, 4, 1};
    int d2[13] = '{16, 32, 8, 16, 32, 2, 1, 8, 4, 4, 1, 2, 2};
    return g2 ? d2[i] : d1[i];
  endfunction

  function automatic int exp_word(input bit g2, input int i);
    int w1[7]  = '{0, 'h000, 'h133, 0, 0, 0, 'h033};
    int w2[13] = '{0, 0, 0, 0, 0, 'h402, 'h143, 0, 0, 0, 'h043, 'h782, 'h402};
    return g2 ? w2[i] : w1[i];
  endfunction

  function automatic int exp_wait(input bit g2, input int i);
    return (g2 && i < 2) ? SH : LG;
  endfunction

  task automatic run_capture(input bit g2, input bit poke_start, input bit flip_sel);
    int cyc;
    int pm, pe;
    cap_n = 0;
    done_cyc = -1;
    cyc = 0;
    ddr2_sel = g2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    pm = mode_word; pe = emode_word;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      cyc++;
      start = (poke_start && c == 15);
      if (flip_sel && c == 12) ddr2_sel = !g2;
      if (c == 4) chk(busy == 1'b1, "R9", "busy during run", busy, 1);
      if (cmd_strobe != 0 && cap_n < 16) begin
        cap_cmd[cap_n]    = cmd_strobe;
        cap_word_m[cap_n] = mode_word;
        cap_word_e[cap_n] = emode_word;
        cap_prev_m[cap_n] = pm;
        cap_prev_e[cap_n] = pe;
        cap_cyc[cap_n]    = cyc;
        cap_n++;
      end
      if (done) begin
        done_cyc = cyc;
        break;
      end
      pm = mode_word;
      pe = emode_word;
    end
    start = 1'b0;
  endtask

  task automatic verify_run(input bit g2);
    string rq;
    chk(cap_n == exp_len(g2), g2 ? "R3" : "R2", "strobe count", cap_n, exp_len(g2));
    for (int i = 0; i < cap_n && i < exp_len(g2); i++) begin
      rq = g2 ? ((i >= 11) ? "R4" : "R3") : "R2";
      chk(cap_cmd[i] == exp_cmd(g2, i), rq, $sformatf("strobe %0d code", i),
          cap_cmd[i], exp_cmd(g2, i));
      chk($countones(cap_cmd[i]) == 1, "R1", "single bit strobe", cap_cmd[i], exp_cmd(g2, i));
      if (exp_cmd(g2, i) == 1) begin
        chk(cap_word_m[i] == exp_word(g2, i), rq, $sformatf("mode word at %0d", i),
            cap_word_m[i], exp_word(g2, i));
        chk(cap_prev_m[i] == cap_word_m[i], "R5", "mode word setup", cap_prev_m[i], cap_word_m[i]);
      end
      if (exp_cmd(g2, i) == 2) begin
        chk(cap_word_e[i] == exp_word(g2, i), rq, $sformatf("ext word at %0d", i),
            cap_word_e[i], exp_word(g2, i));
        chk(cap_prev_e[i] == cap_word_e[i], "R5", "ext word setup", cap_prev_e[i], cap_word_e[i]);
      end
      if (i > 0)
        chk(cap_cyc[i] - cap_cyc[i-1] == exp_wait(g2, i-1) + 2, "R6",
            $sformatf("gap before strobe %0d", i),
            cap_cyc[i] - cap_cyc[i-1], exp_wait(g2, i-1) + 2);
    end
    if (cap_n > 0)
      chk(done_cyc - cap_cyc[cap_n-1] == LG, "R6", "last strobe to done",
          done_cyc - cap_cyc[cap_n-1], LG);
    chk(refresh_ctrl_word == 16'h4138, "R7", "refresh word", refresh_ctrl_word, 16'h4138);
    chk(dqs_tap_lane0 == (g2 ? 6'h10 : 6'h20), "R8", "tap lane 0", dqs_tap_lane0, g2 ? 6'h10 : 6'h20);
    chk(dqs_tap_lane1 == (g2 ? 6'h10 : 6'h20), "R8", "tap lane 1", dqs_tap_lane1, g2 ? 6'h10 : 6'h20);
    chk(busy == 1'b0, "R9", "busy after done", busy, 0);
  endtask

  task automatic test_reset_state();
    do_reset();
    chk(cmd_strobe == 0, "R1", "strobe at reset", cmd_strobe, 0);
    chk(done == 0, "R9", "done at reset", done, 0);
    chk(busy == 0, "R9", "busy at reset", busy, 0);
    chk(refresh_ctrl_word == 0, "R7", "refresh word at reset", refresh_ctrl_word, 0);
    chk(dqs_tap_lane0 == 0 && dqs_tap_lane1 == 0, "R8", "taps at reset", dqs_tap_lane0, 0);
  endtask

  task automatic test_no_start();
    int seen = 0;
    do_reset();
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (cmd_strobe != 0 || busy) seen++;
    end
    chk(seen == 0, "R10", "activity without start", seen, 0);
  endtask

  task automatic test_gen1_with_flip();
    do_reset();
    run_capture(1'b0, 1'b0, 1'b1);
    verify_run(1'b0);
    chk(dqs_tap_lane0 == 6'h20, "R11", "variant held after select flip", dqs_tap_lane0, 6'h20);
  endtask

  task automatic test_gen2_with_restart();
    do_reset();
    run_capture(1'b1, 1'b1, 1'b0);
    verify_run(1'b1);
    chk(cap_n == 13, "R10", "mid-run start ignored", cap_n, 13);
  endtask

  task automatic test_gen2_with_flip();
    do_reset();
    run_capture(1'b1, 1'b0, 1'b1);
    verify_run(1'b1);
    chk(dqs_tap_lane1 == 6'h10, "R11", "variant held after select flip", dqs_tap_lane1, 6'h10);
  endtask

  task automatic test_after_done();
    int seen = 0;
    int ref0;
    do_reset();
    run_capture(1'b0, 1'b0, 1'b0);
    ref0 = refresh_ctrl_word;
    ddr2_sel = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (cmd_strobe != 0 || busy || !done) seen++;
    end
    chk(seen == 0, "R9", "done sticky and quiet", seen, 0);
    chk(seen == 0, "R10", "start after done ignored", seen, 0);
    chk(refresh_ctrl_word == ref0, "R7", "refresh word held", refresh_ctrl_word, ref0);
    chk(dqs_tap_lane0 == 6'h20, "R8", "tap held after late start", dqs_tap_lane0, 6'h20);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset_state();
    test_no_start();
    test_gen1_with_flip();
    test_gen2_with_restart();
    test_gen2_with_flip();
    test_after_done();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule